// File: doc/BRIEF.md
# Six-Switch Overcurrent Limit Controller

This block sits between the six PWM gate requests of a three-phase bridge (high and low switch of each phase) and the gate enables that leave for the drivers. Each switch has an overcurrent flag from an external sensing comparator. When a switch that is conducting raises its flag, the block blanks that switch. It also pulls an active-low warning output low, so that a host controller has time to sample the event.

Two families of behaviour are chosen by a two-bit mode input. Code 0 is current limiting. Inside current limiting, one select bit chooses between two sub-modes. In cycle-by-cycle limiting, a tripped switch stays off until its own request starts a new PWM cycle. In off-time limiting, tripped switches stay off for a fixed window. Every other mode code treats any overcurrent as a latched fault that turns all gates off until a clear pulse. A shutdown input removes every gate enable at once.

All six switches share one off-time counter, and the warning stretch uses the same counter. Each new trip restarts the counter. PWM requests pass through a synchronizer before they are used. Overcurrent flags are taken as already synchronous to the clock.

Top module: `oc_lim_ctrl`

## Requirements
- R1: While reset is asserted, every gate enable is 0 and the warning output is 1. After reset, no switch is blanked and no fault is latched.
- R2: Gate enable i is 1 exactly when switch i's request, delayed by SYNC_STAGES clock edges, is 1 and switch i is not blanked, no fault is latched, and shutdown is low.
- R3: A trip is an overcurrent flag raised by a switch whose gate enable is 1. With mode code 0 and select bit 0 (cycle-by-cycle), a tripped switch is blanked from the next edge until one edge after its synchronized request rises again.
- R4: With mode code 0 and select bit 1 (off-time), a tripped switch's gate enable is 0 for OFF_CYC cycles. It then returns to 1 if the request is still high.
- R5: The off-time counter is shared and restarts on every trip. A blanked switch is released only OFF_CYC cycles after the most recent trip on any switch.
- R6: In off-time mode, a change of level in a tripped switch's synchronized request releases that switch early. Other tripped switches stay off until the shared window ends.
- R7: The warning goes low at the edge after a trip. It returns high once the synchronized request of every switch that tripped has fallen, or OFF_CYC cycles after the last trip, whichever is first.
- R8: A trip while the warning is held keeps the warning low and restarts its OFF_CYC window.
- R9: Shutdown forces all gate enables to 0 in the same cycle. An overcurrent flag raised during shutdown does not pull the warning low.
- R10: With a mode code other than 0, a trip latches a fault. The fault holds every gate enable at 0 and the warning low, even across new PWM cycles, until fault_clr is sampled high.
- R11: An overcurrent flag on a switch whose request is low has no effect on the warning or on later gate enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_req | input | 6 | PWM gate requests, bit 2k = high switch, bit 2k+1 = low switch of phase k |
| oc_flag | input | 6 | Per-switch overcurrent flags, same bit order |
| oc_mode | input | 2 | 0 = current limiting, other codes = latched fault |
| limit_sel | input | 1 | Current-limit sub-mode: 0 = cycle-by-cycle, 1 = off-time |
| shutdown | input | 1 | Forces all gate enables low |
| fault_clr | input | 1 | Clears a latched fault |
| gate_en | output | 6 | Gate enables to the drivers |
| warn_n | output | 1 | Active-low overcurrent warning |

## Verification
The bench builds the block with OFF_CYC set to 16 and SYNC_STAGES left at 2. The short window lets one bench reach counter expiry, a restart by a second trip on another switch, and an early release by a request toggle, all in a few dozen cycles. With two synchronizer stages, every gate change lands at a fixed, predictable edge after a request change.

// File: rtl/oc_lim_pkg.sv
package oc_lim_pkg;

  localparam int NUM_SW = 6;

  typedef logic [NUM_SW-1:0] sw_vec_t;

  typedef enum logic {
    LIM_CBC     = 1'b0,
    LIM_OFFTIME = 1'b1
  } lim_sub_e;

  localparam logic [1:0] OCM_LIMIT = 2'b00;

  // gate is the synchronized request with blanked switches removed and a
  // global hold (latched fault or shutdown) applied
  function automatic sw_vec_t gate_mask(sw_vec_t req, sw_vec_t blank, logic hold);
    sw_vec_t g;
    g = req & ~blank;
    if (hold) g = '0;
    return g;
  endfunction

  // switches whose PWM cycle is still open after a trip
  function automatic sw_vec_t pend_update(sw_vec_t pend, sw_vec_t fall,
                                          sw_vec_t trip, logic expire);
    sw_vec_t n;
    if (expire) n = trip;
    else        n = (pend & ~fall) | trip;
    return n;
  endfunction

endpackage

// File: rtl/oc_lim_sync.sv
module oc_lim_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/oc_lim_timer.sv
module oc_lim_timer #(
  parameter int CYC = 12800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done_o
);
  localparam int CW = (CYC > 2) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign done_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (load) begin
      run_q <= 1'b1;
      cnt_q <= LOAD_VAL;
    end else if (done_o) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !load && cnt_q != '0) |=> (run_q && cnt_q == $past(cnt_q) - CW'(1)));

  assert_done_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !load) |=> !done_o);
endmodule

// File: rtl/oc_lim_switch.sv
module oc_lim_switch
  import oc_lim_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  lim_sub_e sub,
  input  logic     arm,
  input  logic     trip,
  input  logic     rise,
  input  logic     toggle,
  input  logic     expire,
  output logic     blank_o
);
  logic blank_q;
  logic release_ev;

  always_comb begin
    if (sub == LIM_CBC) release_ev = rise;
    else                release_ev = toggle || expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                blank_q <= 1'b0;
    else if (trip && arm)      blank_q <= 1'b1;
    else if (blank_q && release_ev) blank_q <= 1'b0;
  end

  assign blank_o = blank_q;

  assert_blank_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blank_q) |-> $past(trip && arm));

  assert_cbc_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(blank_q) && $past(sub) == LIM_CBC) |-> $past(rise));

  assert_offtime_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(blank_q) && $past(sub) == LIM_OFFTIME) |-> $past(toggle || expire));
endmodule

// File: rtl/oc_lim_ctrl.sv
module oc_lim_ctrl
  import oc_lim_pkg::*;
#(
  parameter int OFF_CYC     = 12800,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] pwm_req,
  input  logic [5:0] oc_flag,
  input  logic [1:0] oc_mode,
  input  logic       limit_sel,
  input  logic       shutdown,
  input  logic       fault_clr,
  output logic [5:0] gate_en,
  output logic       warn_n
);
  sw_vec_t  pwm_s, pwm_d_q, rise, fall, toggle;
  sw_vec_t  blank, gate_on, trip, pend_q, pend_next;
  logic     any_trip, limit_mode, hold_off;
  logic     latch_q, latch_next;
  logic     tmr_done, expire;
  logic     warn_act_q;
  lim_sub_e sub_mode;

  oc_lim_sync #(.W(NUM_SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pwm_req),
    .dout (pwm_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_d_q <= '0;
    else        pwm_d_q <= pwm_s;
  end

  assign rise   = pwm_s & ~pwm_d_q;
  assign fall   = ~pwm_s & pwm_d_q;
  assign toggle = pwm_s ^ pwm_d_q;

  assign limit_mode = (oc_mode == OCM_LIMIT);
  assign sub_mode   = lim_sub_e'(limit_sel);
  assign hold_off   = latch_q | shutdown;
  assign gate_on    = gate_mask(pwm_s, blank, hold_off);
  assign trip       = oc_flag & gate_on;
  assign any_trip   = |trip;

  oc_lim_timer #(.CYC(OFF_CYC)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (any_trip),
    .done_o(tmr_done)
  );

  assign expire = tmr_done & ~any_trip;

  for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
    oc_lim_switch u_sw (
      .clk    (clk),
      .rst_n  (rst_n),
      .sub    (sub_mode),
      .arm    (limit_mode),
      .trip   (trip[i]),
      .rise   (rise[i]),
      .toggle (toggle[i]),
      .expire (expire),
      .blank_o(blank[i])
    );
  end

  assign latch_next = fault_clr ? 1'b0 : (latch_q | (any_trip & ~limit_mode));
  assign pend_next  = pend_update(pend_q, fall, trip, expire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q    <= 1'b0;
      pend_q     <= '0;
      warn_act_q <= 1'b0;
    end else begin
      latch_q    <= latch_next;
      pend_q     <= pend_next;
      warn_act_q <= (|pend_next) | latch_next;
    end
  end

  assign gate_en = gate_on;
  assign warn_n  = ~warn_act_q;

  assert_warn_on_trip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any_trip |=> !warn_n);

  assert_shutdown_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && warn_n && !latch_q && pend_q == '0) |=> warn_n);

  assert_latch_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    latch_q |-> (gate_en == '0 && !warn_n));

  assert_shutdown_gates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown) |-> gate_en == '0);
endmodule

// File: tb/test_oc_lim_ctrl.sv
`timescale 1ns/100ps
module test_oc_lim_ctrl;
  localparam int OFF = 16;

  typedef struct packed {
    logic [5:0] pwm;
    logic [5:0] oc;
    logic [7:0] wait_c;
    logic [5:0] gate;
    logic       warn;
  } vec_t;

  // cycle-by-cycle sequence (R3, R7, R2)
  localparam vec_t VECS [9] = '{
    '{6'h3F, 6'h00, 8'd3,  6'h3F, 1'b1},
    '{6'h3F, 6'h01, 8'd1,  6'h3E, 1'b0},
    '{6'h3F, 6'h00, 8'd5,  6'h3E, 1'b0},
    '{6'h3E, 6'h00, 8'd3,  6'h3E, 1'b1},
    '{6'h3F, 6'h00, 8'd3,  6'h3F, 1'b1},
    '{6'h3F, 6'h0C, 8'd1,  6'h33, 1'b0},
    '{6'h3F, 6'h00, 8'd20, 6'h33, 1'b1},
    '{6'h33, 6'h00, 8'd3,  6'h33, 1'b1},
    '{6'h3F, 6'h00, 8'd3,  6'h3F, 1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic [5:0] pwm_req = '0, oc_flag = '0;
  logic [1:0] oc_mode = '0;
  logic limit_sel = 0, shutdown = 0, fault_clr = 0;
  logic [5:0] gate_en;
  logic warn_n;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  oc_lim_ctrl #(.OFF_CYC(OFF), .SYNC_STAGES(2)) i_oc_lim_ctrl (
    .clk(clk), .rst_n(rst_n), .pwm_req(pwm_req), .oc_flag(oc_flag),
    .oc_mode(oc_mode), .limit_sel(limit_sel), .shutdown(shutdown),
    .fault_clr(fault_clr), .gate_en(gate_en), .warn_n(warn_n)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk_gate(input logic [5:0] exp, input string req);
    checks++;
    if (gate_en !== exp) begin
      fails++;
      $display("FAIL %s gate_en actual=%h expected=%h", req, gate_en, exp);
    end
  endtask

  task automatic chk_warn(input logic exp, input string req);
    checks++;
    if (warn_n !== exp) begin
      fails++;
      $display("FAIL %s warn_n actual=%b expected=%b", req, warn_n, exp);
    end
  endtask

  task automatic pulse_oc(input logic [5:0] m);
    oc_flag = m;
    step(1);
    oc_flag = '0;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    // R1 reset state
    step(3);
    chk_gate(6'h00, "R1");
    chk_warn(1'b1, "R1");
    rst_n = 1;
    step(2);

    // table walk: cycle-by-cycle mode (R2 R3 R7)
    for (int k = 0; k < 9; k++) begin
      pwm_req = VECS[k].pwm;
      oc_flag = VECS[k].oc;
      step(1);
      oc_flag = '0;
      step(int'(VECS[k].wait_c) - 1);
      chk_gate(VECS[k].gate, "R3");
      chk_warn(VECS[k].warn, "R7");
    end

    // R4 off-time window
    limit_sel = 1;
    step(1);
    pulse_oc(6'h01);
    chk_gate(6'h3E, "R4");
    step(OFF - 1);
    chk_gate(6'h3E, "R4");
    step(1);
    chk_gate(6'h3F, "R4");

    // R5 shared counter restart
    pulse_oc(6'h01);
    step(7);
    pulse_oc(6'h02);
    step(OFF - 1);
    chk_gate(6'h3C, "R5");
    step(1);
    chk_gate(6'h3F, "R5");

    // R6 toggle releases one switch early
    pulse_oc(6'h03);
    chk_gate(6'h3C, "R6");
    pwm_req = 6'h3E;
    step(2);
    pwm_req = 6'h3F;
    step(2);
    chk_gate(6'h3D, "R6");
    step(OFF - 5);
    chk_gate(6'h3D, "R6");
    step(1);
    chk_gate(6'h3F, "R6");

    // R8 warning restart in cycle-by-cycle mode
    limit_sel = 0;
    step(1);
    pulse_oc(6'h01);
    step(9);
    pulse_oc(6'h02);
    step(OFF - 9);
    chk_warn(1'b0, "R8");
    step(8);
    chk_warn(1'b0, "R8");
    step(1);
    chk_warn(1'b1, "R8");
    pwm_req = 6'h00;
    step(3);
    pwm_req = 6'h3F;
    step(3);
    chk_gate(6'h3F, "R3");

    // R9 shutdown
    shutdown = 1;
    #1;
    chk_gate(6'h00, "R9");
    pulse_oc(6'h3F);
    chk_warn(1'b1, "R9");
    shutdown = 0;
    #1;
    chk_gate(6'h3F, "R9");

    // R11 flag on an idle switch
    pwm_req = 6'h3E;
    step(3);
    pulse_oc(6'h01);
    chk_warn(1'b1, "R11");
    chk_gate(6'h3E, "R11");
    pwm_req = 6'h3F;
    step(3);
    chk_gate(6'h3F, "R11");

    // R10 latched fault
    oc_mode = 2'b01;
    step(1);
    pulse_oc(6'h04);
    chk_gate(6'h00, "R10");
    chk_warn(1'b0, "R10");
    pwm_req = 6'h00;
    step(3);
    pwm_req = 6'h3F;
    step(3 + OFF);
    chk_gate(6'h00, "R10");
    chk_warn(1'b0, "R10");
    fault_clr = 1;
    step(1);
    fault_clr = 0;
    chk_gate(6'h3F, "R10");
    chk_warn(1'b1, "R10");

    report();
    $finish;
  end
endmodule